// File: doc/BRIEF.md
# NOR Flash Command Sequencer with Status Polling

This block models the command side of a parallel NOR flash. Software issues single-cycle writes on a strobe bus, and the block decodes them as multi-write unlock sequences. Two commands are recognised: a byte program and a whole-array erase. When a command is accepted, the block starts an internal operation that lasts a fixed, parameterised number of clock cycles. While it runs, a busy output is high and the synchronous storage array cannot be read. Reads during this time return status bits that software polls to detect completion.

Every write that arrives while an operation runs is discarded. A write that does not fit the expected sequence sends the decoder back to its idle state and has no other effect. When an erase completes, every location holds all ones. When a program completes, the addressed location holds the written byte.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy is 0, rd_data is 00h, and every array location reads FFh.
- R2: Four writes program a byte: AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then the target address and data. After the operation, the location given by the low IDX_W address bits reads back the data.
- R3: Six writes erase the whole array: AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 10h at 5555h. After the operation, every location reads FFh.
- R4: busy rises in the cycle after the final write of an accepted command. It stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase.
- R5: During a program, a read returns the complement of bit 7 of the byte being programmed on bit 7.
- R6: During an erase, a read returns 0 on bit 7.
- R7: During an operation, bit 6 of successive reads inverts on every read, and bits 5:0 read 0.
- R8: Writes made while busy is high have no effect, including a complete command sequence. The decoder is idle when the operation ends.
- R9: A write that breaks a sequence returns the decoder to idle without changing the array. A later correct sequence is still accepted.
- R10: rd_data is registered. It shows the result of a read in the cycle after rd_en and holds that value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | IDX_W | Array index for a read |
| rd_data | output | 8 | Registered read data or status |
| busy | output | 1 | Internal program or erase in progress |

## Verification
The hardest situation to reach from the ports is a complete, valid command sequence that arrives while an erase is running. The decoder must discard it silently and still be idle afterwards.

The stimulus starts an erase and reads status twice. It then writes a full program sequence and reads again, all inside the erase window. After the erase it sends a lone data write, which would program a location only if the decoder had been left waiting for a target. The bench then confirms that the array is all ones. Random programs and random non-command writes, which never carry AAh, cover the ordinary and broken-sequence paths.

// File: rtl/nor_cmd_pkg.sv
// Shared constants and types for the flash command sequencer.
// Assumes 8-bit data and unlock keys at fixed 16-bit addresses.
package nor_cmd_pkg;
    localparam logic [15:0] KEY_ADDR_HI = 16'h5555;
    localparam logic [15:0] KEY_ADDR_LO = 16'h2AAA;
    localparam logic [7:0]  KEY_FIRST   = 8'hAA;
    localparam logic [7:0]  KEY_SECOND  = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_SETUP = 8'h80;
    localparam logic [7:0]  CMD_ERASE_ALL   = 8'h10;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERA1, SQ_ERA2, SQ_ERA3
    } seq_state_t;
endpackage

// File: rtl/nor_seq_decoder.sv
// Command sequence decoder: walks the unlock sequence one write at a time
// and pulses a start for program or erase. Assumes writes are one-cycle
// strobes; every write is ignored while busy is high.
module nor_seq_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              start_prog,
    output logic              start_erase
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(KEY_ADDR_HI);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(KEY_ADDR_LO);

    seq_state_t state, state_nx;
    logic at_hi, at_lo;

    assign at_hi = (wr_addr == A_HI);
    assign at_lo = (wr_addr == A_LO);

    // Next-state and start decode for an accepted write
    always_comb begin
        state_nx    = state;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        if (wr_en && !busy) begin
            state_nx = SQ_IDLE;
            case (state)
                SQ_IDLE: if (at_hi && wr_data == KEY_FIRST)  state_nx = SQ_UNL1;
                SQ_UNL1: if (at_lo && wr_data == KEY_SECOND) state_nx = SQ_UNL2;
                SQ_UNL2: begin
                    if (at_hi && wr_data == CMD_PROG)             state_nx = SQ_PGM;
                    else if (at_hi && wr_data == CMD_ERASE_SETUP) state_nx = SQ_ERA1;
                end
                SQ_PGM:  start_prog = 1'b1;
                SQ_ERA1: if (at_hi && wr_data == KEY_FIRST)  state_nx = SQ_ERA2;
                SQ_ERA2: if (at_lo && wr_data == KEY_SECOND) state_nx = SQ_ERA3;
                SQ_ERA3: start_erase = at_hi && (wr_data == CMD_ERASE_ALL);
                default: state_nx = SQ_IDLE;
            endcase
        end
    end

    // Sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    assert_idle_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state == SQ_IDLE));
    assert_start_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase}));
endmodule

// File: rtl/nor_op_timer.sv
// Operation timer: holds busy for a fixed cycle count after a start and
// pulses done on the last busy cycle. Assumes starts only arrive while idle.
module nor_op_timer #(
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy,
    output logic erase_op,
    output logic done
);
    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    // Load, count down and release busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            erase_op <= 1'b0;
            cnt      <= '0;
        end else if (start_prog || start_erase) begin
            busy     <= 1'b1;
            erase_op <= start_erase;
            cnt      <= start_erase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |=> busy);
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy);
    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_prog || start_erase));
endmodule

// File: rtl/nor_store.sv
// Storage array with status read path. Latches the program target on start,
// commits on done, and returns polling status while busy. Assumes reset
// fills the array with ones.
module nor_store #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_prog,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             busy,
    input  logic             erase_op,
    input  logic             done,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] tgt_idx;
    logic [7:0]       tgt_data;
    logic             toggle;

    // Capture program target when the command is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_idx  <= '0;
            tgt_data <= '0;
        end else if (start_prog) begin
            tgt_idx  <= wr_idx;
            tgt_data <= wr_data;
        end
    end

    // Array contents: reset to ones, commit program or erase at done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (done) begin
            if (erase_op) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            end else begin
                mem[tgt_idx] <= tgt_data;
            end
        end
    end

    // Read path: status while busy, array data otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            toggle  <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= {(erase_op ? 1'b0 : ~tgt_data[7]), toggle, 6'b0};
                toggle  <= ~toggle;
            end else begin
                rd_data <= mem[rd_idx];
            end
        end
    end

    assert_erase_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && erase_op) |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
    assert_erase_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && erase_op) |=> (rd_data[7] == 1'b0));
    assert_status_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_data[5:0] == 6'b0));
    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !$past(!rst_n)) |=> $stable(rd_data));
endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the flash command sequencer: decoder, operation timer and array.
// Assumes one write or one read per cycle from a single host.
module nor_cmd_seq #(
    parameter int ADDR_W       = 16,
    parameter int DEPTH        = 64,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 60,
    parameter int IDX_W        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic start_prog, start_erase, erase_op, done;

    nor_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy),
        .start_prog(start_prog), .start_erase(start_erase)
    );

    nor_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
        .busy(busy), .erase_op(erase_op), .done(done)
    );

    nor_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog),
        .wr_idx(wr_addr[IDX_W-1:0]), .wr_data(wr_data), .busy(busy),
        .erase_op(erase_op), .done(done), .rd_en(rd_en), .rd_idx(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 64;
    localparam int IDX_W  = 6;
    localparam int PCYC   = 20;
    localparam int ECYC   = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [IDX_W-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic busy;

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [DEPTH];
    logic tog = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROG_CYCLES(PCYC),
                  .ERASE_CYCLES(ECYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [7:0] busy_status(logic is_erase, logic [7:0] d, logic t);
        return {(is_erase ? 1'b0 : ~d[7]), t, 6'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [IDX_W-1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic prog_seq(logic [15:0] a, logic [7:0] d);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_seq();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h10);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
    endtask

    task automatic check_all(string req);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            rd(IDX_W'(i), v); check(req, v, model[i]);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int cnt;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 rd_data", rd_data, 0);
        check_all("R1 array");

        // R2/R4: directed program with duration measurement
        prog_seq(16'h0012, 8'h3C);
        check("R4 busy rise", busy, 1);
        cnt = 0;
        while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
        check("R4 program length", cnt, PCYC);
        model[6'h12] = 8'h3C;
        rd(6'h12, v); check("R2 readback", v, 8'h3C);
        // R10: value held with rd_en low
        repeat (3) @(negedge clk);
        check("R10 hold", rd_data, 8'h3C);

        // R5/R7: status during program, bit 7 of data set
        prog_seq(16'hC021, 8'hA5);
        for (int k = 0; k < 3; k++) begin
            rd(6'h21, v);
            check("R5/R7 program status", v, busy_status(1'b0, 8'hA5, tog));
            tog = ~tog;
        end
        wait_idle();
        model[6'h21] = 8'hA5;
        rd(6'h21, v); check("R2 after status", v, 8'hA5);
        // R5 with bit 7 clear
        prog_seq(16'h0003, 8'h41);
        rd(6'h03, v); check("R5 complement", v, busy_status(1'b0, 8'h41, tog)); tog = ~tog;
        wait_idle(); model[3] = 8'h41;

        // R2: random programs
        for (int k = 0; k < 20; k++) begin
            logic [15:0] a; logic [7:0] d;
            a = 16'($urandom); d = 8'($urandom);
            prog_seq(a, d);
            if (k % 4 == 0) begin
                rd(a[IDX_W-1:0], v);
                check("R5/R7 random status", v, busy_status(1'b0, d, tog)); tog = ~tog;
            end
            wait_idle();
            model[a[IDX_W-1:0]] = d;
        end
        check_all("R2 random");

        // R9: random non-command writes never start anything
        for (int k = 0; k < 30; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (d == 8'hAA) d = 8'h00;
            wr(16'($urandom), d);
            check("R9 no busy", busy, 0);
        end
        // R9: broken program and broken erase sequences
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h77);
        wr(16'h0005, 8'h00);
        check("R9 broken prog busy", busy, 0);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h30);
        check("R9 broken erase busy", busy, 0);
        wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0);
        wr(16'h0006, 8'h00);
        check("R9 wrong addr busy", busy, 0);
        check_all("R9 unchanged");
        prog_seq(16'h0005, 8'h5A);
        check("R9 recover busy", busy, 1);
        wait_idle(); model[5] = 8'h5A;
        rd(6'h05, v); check("R9 recover data", v, 8'h5A);

        // R3/R4: erase with duration measurement
        erase_seq();
        check("R4 erase busy rise", busy, 1);
        cnt = 0;
        while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
        check("R4 erase length", cnt, ECYC);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        check_all("R3 erased");

        // R6/R7/R8: erase with status reads and an ignored program sequence
        prog_seq(16'h0009, 8'h12); wait_idle();
        erase_seq();
        for (int k = 0; k < 2; k++) begin
            rd(6'h09, v); check("R6/R7 erase status", v, busy_status(1'b1, 8'h00, tog)); tog = ~tog;
        end
        prog_seq(16'h0009, 8'h00);
        check("R8 still busy", busy, 1);
        for (int k = 0; k < 2; k++) begin
            rd(6'h09, v); check("R6/R7 erase status late", v, busy_status(1'b1, 8'h00, tog)); tog = ~tog;
        end
        wait_idle();
        // R8: decoder idle afterwards, lone write does not program
        wr(16'h0007, 8'h00);
        check("R8 idle after op", busy, 0);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        check_all("R8/R3 after erase");

        finish_run();
    end
endmodule